// File: doc/BRIEF.md
# Eight-Lane Transport Mapper for a Single 14-Bit Converter

This block turns a stream of 14-bit samples for one converter into the transport-layer lane data of an eight-lane JESD204B link. The link carries one octet per frame and four samples per frame. Each sample is widened to 16 bits by adding two tail bits below its least significant bit. Its upper octet goes on one lane of a fixed pair and its lower octet on the other. No control bits are carried, so every octet on an odd lane ends in the two tail bits.

Each clock beat takes sixteen samples and produces one 32-bit word per lane. Each lane word holds four frames in time order, with the earliest frame in the lowest octet. A beat counter tracks the eight beats of a 32-frame multiframe and flags the first and last beat. By default the tail bits are zero. A mode input can replace them with a short pseudo-random sequence that advances once per sample.

Top module: `jtm_transport_mapper`

## Requirements
- R1: For sample k of a frame (k = 0..3), lane 2k carries the sample's bits [13:6] as that frame's octet.
- R2: Lane 2k+1 carries the same sample's bits [5:0] in octet bits [7:2], with the two tail bits in octet bits [1:0].
- R3: Input sample i (bits [14i+13:14i] of `in_samples`, i = 0..15) belongs to frame i/4 as sample i%4. Frame f occupies bits [8f+7:8f] of every lane word. Lane l occupies bits [32l+31:32l] of `lane_data`.
- R4: With `tail_rand` low on the accepted beat, every tail bit pair is 00.
- R5: With `tail_rand` high, the tail of the n-th sample accepted since reset (n counted from 0 over all accepted samples in either mode) is 01, 11 or 10 for n mod 3 = 0, 1 or 2.
- R6: A beat is accepted when `in_valid` and `in_ready` are both high. `out_valid` is high exactly in the cycle after an accepted beat, and that beat's lane data appears in the same cycle. Lane data holds its value when no beat is accepted.
- R7: `in_ready` equals `link_start`.
- R8: `mf_start` is high with the output of beat 0 of a multiframe and `mf_end` with the output of beat 7. The beat number counts accepted beats modulo 8. Both flags are low whenever `out_valid` is low.
- R9: A low `link_start` or a reset returns the beat count to 0, so the next accepted beat is beat 0.
- R10: `frame_end` is all ones: every octet on every lane closes a frame.
- R11: After reset, `out_valid`, `mf_start`, `mf_end` and `lane_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_start | input | 1 | Link running; low holds the beat count at 0 and refuses input |
| tail_rand | input | 1 | Selects pseudo-random tail bits instead of zeros |
| in_valid | input | 1 | A beat of sixteen samples is offered |
| in_ready | output | 1 | Beat can be accepted |
| in_samples | input | 224 | Sixteen 14-bit samples, sample 0 earliest in the lowest bits |
| out_valid | output | 1 | Lane words hold a newly accepted beat |
| lane_data | output | 256 | Eight 32-bit lane words |
| mf_start | output | 1 | Current output is the first beat of a multiframe |
| mf_end | output | 1 | Current output is the last beat of a multiframe |
| frame_end | output | 32 | End-of-frame marker per lane per octet |

## Verification
The hardest situation to reach is a tail pattern that runs on across beats of differing history. The tail sequence has period three, but sixteen samples are accepted per beat. Its phase therefore drifts by one sample each beat, advances in zero mode too, and halts during stalls. The bench counts every accepted sample from reset and derives the expected tail from that count. The run covers zero-tail beats, then stalls, then a link drop in the middle of a multiframe, then random-tail beats with gaps, and finally a fresh reset. Every phase the sequence can start a beat in is therefore visited under both tail modes and across multiframe restarts.

// File: rtl/jtm_pkg.sv
package jtm_pkg;

    localparam int LANES           = 8;
    localparam int SMP_PER_FRAME   = 4;
    localparam int FRAMES_PER_BEAT = 4;
    localparam int RES_BITS        = 14;
    localparam int SMP_BITS        = 16;
    localparam int OCT_BITS        = 8;
    localparam int K_FRAMES        = 32;

    localparam int TAIL_BITS       = SMP_BITS - RES_BITS;
    localparam int SMP_PER_BEAT    = SMP_PER_FRAME * FRAMES_PER_BEAT;
    localparam int LANE_W          = OCT_BITS * FRAMES_PER_BEAT;
    localparam int BEATS_PER_MF    = K_FRAMES / FRAMES_PER_BEAT;
    localparam int BEAT_CNT_W      = (BEATS_PER_MF > 1) ? $clog2(BEATS_PER_MF) : 1;
    localparam int IN_W            = SMP_PER_BEAT * RES_BITS;
    localparam int OUT_W           = LANES * LANE_W;
    localparam int MARK_W          = LANES * FRAMES_PER_BEAT;

    typedef logic [RES_BITS-1:0]  sample_t;
    typedef logic [TAIL_BITS-1:0] tail_t;
    typedef logic [SMP_BITS-1:0]  padded_t;
    typedef logic [LANE_W-1:0]    lane_word_t;
    typedef logic [BEAT_CNT_W-1:0] beat_cnt_t;

    typedef sample_t    [SMP_PER_BEAT-1:0] beat_samples_t;
    typedef tail_t      [SMP_PER_BEAT-1:0] beat_tails_t;
    typedef lane_word_t [LANES-1:0]        lane_bus_t;

    typedef struct packed {
        logic first;
        logic last;
    } mf_pos_t;

    localparam tail_t TAIL_SEED = tail_t'(1);

    // Two-bit maximal sequence: 01 -> 11 -> 10 -> 01
    function automatic tail_t tail_step(input tail_t s);
        return {s[0], s[1] ^ s[0]};
    endfunction

    function automatic padded_t pad_sample(input sample_t s, input tail_t t);
        return {s, t};
    endfunction

endpackage

// File: rtl/jtm_tail_gen.sv
module jtm_tail_gen
    import jtm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        advance,
    input  logic        rand_en,
    output beat_tails_t tails
);

    tail_t state_q;
    tail_t chain [SMP_PER_BEAT+1];

    assign chain[0] = state_q;

    for (genvar j = 0; j < SMP_PER_BEAT; j++) begin : g_chain
        assign chain[j+1] = tail_step(chain[j]);
        assign tails[j]   = rand_en ? chain[j] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TAIL_SEED;
        end else if (advance) begin
            state_q <= chain[SMP_PER_BEAT];
        end
    end

endmodule

// File: rtl/jtm_lane_packer.sv
module jtm_lane_packer
    import jtm_pkg::*;
(
    input  beat_samples_t samples,
    input  beat_tails_t   tails,
    output lane_bus_t     lanes
);

    always_comb begin
        lanes = '0;
        for (int f = 0; f < FRAMES_PER_BEAT; f++) begin
            for (int k = 0; k < SMP_PER_FRAME; k++) begin
                padded_t d;
                d = pad_sample(samples[f*SMP_PER_FRAME + k],
                               tails[f*SMP_PER_FRAME + k]);
                lanes[2*k][f*OCT_BITS +: OCT_BITS]   = d[SMP_BITS-1 -: OCT_BITS];
                lanes[2*k+1][f*OCT_BITS +: OCT_BITS] = d[OCT_BITS-1:0];
            end
        end
    end

endmodule

// File: rtl/jtm_mf_counter.sv
module jtm_mf_counter
    import jtm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clear,
    input  logic    advance,
    output mf_pos_t pos
);

    beat_cnt_t cnt_q;

    assign pos.first = (cnt_q == beat_cnt_t'(0));
    assign pos.last  = (cnt_q == beat_cnt_t'(BEATS_PER_MF - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= pos.last ? '0 : cnt_q + beat_cnt_t'(1);
        end
    end

endmodule

// File: rtl/jtm_transport_mapper.sv
module jtm_transport_mapper
    import jtm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              link_start,
    input  logic              tail_rand,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IN_W-1:0]   in_samples,
    output logic              out_valid,
    output logic [OUT_W-1:0]  lane_data,
    output logic              mf_start,
    output logic              mf_end,
    output logic [MARK_W-1:0] frame_end
);

    logic          accept;
    beat_samples_t samples;
    beat_tails_t   tails;
    lane_bus_t     packed_lanes;
    lane_bus_t     lanes_q;
    mf_pos_t       pos;

    assign in_ready  = link_start;
    assign accept    = in_valid && link_start;
    assign samples   = beat_samples_t'(in_samples);
    assign frame_end = '1;
    assign lane_data = OUT_W'(lanes_q);

    jtm_tail_gen u_tail (
        .clk     (clk),
        .rst     (rst),
        .advance (accept),
        .rand_en (tail_rand),
        .tails   (tails)
    );

    jtm_lane_packer u_pack (
        .samples (samples),
        .tails   (tails),
        .lanes   (packed_lanes)
    );

    jtm_mf_counter u_mf (
        .clk     (clk),
        .rst     (rst),
        .clear   (!link_start),
        .advance (accept),
        .pos     (pos)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            mf_start  <= 1'b0;
            mf_end    <= 1'b0;
            lanes_q   <= '0;
        end else begin
            out_valid <= accept;
            mf_start  <= accept && pos.first;
            mf_end    <= accept && pos.last;
            if (accept) begin
                lanes_q <= packed_lanes;
            end
        end
    end

endmodule

// File: rtl/jtm_transport_mapper_chk.sv
module jtm_transport_mapper_chk
    import jtm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              link_start,
    input logic              tail_rand,
    input logic              in_valid,
    input logic              in_ready,
    input logic [IN_W-1:0]   in_samples,
    input logic              out_valid,
    input logic [OUT_W-1:0]  lane_data,
    input logic              mf_start,
    input logic              mf_end,
    input logic [MARK_W-1:0] frame_end
);

    logic acc;
    logic [LANES/2*FRAMES_PER_BEAT*TAIL_BITS-1:0] odd_tails;

    assign acc = in_valid && in_ready;

    always_comb begin
        odd_tails = '0;
        for (int k = 0; k < LANES/2; k++) begin
            for (int f = 0; f < FRAMES_PER_BEAT; f++) begin
                odd_tails[(k*FRAMES_PER_BEAT+f)*TAIL_BITS +: TAIL_BITS] =
                    lane_data[(2*k+1)*LANE_W + f*OCT_BITS +: TAIL_BITS];
            end
        end
    end

    a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(acc)));

    a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(acc)) |-> $stable(lane_data));

    a_r1_first_octet: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc)) |->
        (lane_data[OCT_BITS-1:0] == $past(in_samples[RES_BITS-1:RES_BITS-OCT_BITS])));

    a_r4_zero_tails: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc) && !$past(tail_rand)) |-> (odd_tails == '0));

    a_r8_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
        (mf_start || mf_end) |-> out_valid);

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mf_start, mf_end}));

endmodule

bind jtm_transport_mapper jtm_transport_mapper_chk u_chk (.*);

// File: tb/jtm_transport_mapper_tb.sv
module jtm_transport_mapper_tb;

    localparam int NS  = 16;
    localparam int RB  = 14;
    localparam int NL  = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         link_start;
    logic         tail_rand;
    logic         in_valid;
    logic         in_ready;
    logic [NS*RB-1:0] in_samples;
    logic         out_valid;
    logic [NL*32-1:0] lane_data;
    logic         mf_start;
    logic         mf_end;
    logic [31:0]  frame_end;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    int          n_acc;      // accepted samples since reset
    int          beat_no;    // expected beat number of next accepted beat
    logic [255:0] exp_lanes;
    int          beat_id = 0;

    always #5 clk = ~clk;

    jtm_transport_mapper u_dut (
        .clk        (clk),
        .rst        (rst),
        .link_start (link_start),
        .tail_rand  (tail_rand),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_samples (in_samples),
        .out_valid  (out_valid),
        .lane_data  (lane_data),
        .mf_start   (mf_start),
        .mf_end     (mf_end),
        .frame_end  (frame_end)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [13:0] gen(input int b, input int i);
        if (b % 5 == 3) return 14'h3FFF;
        if (b % 7 == 5) return 14'h0000;
        return 14'((b*16 + i)*613 + b*97);
    endfunction

    function automatic logic [1:0] tail_of(input int n, input bit r);
        if (!r) return 2'b00;
        case (n % 3)
            0: return 2'b01;
            1: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        n_acc = 0;
        beat_no = 0;
        exp_lanes = '0;
        #2;
        // R11 reset state
        chk(out_valid == 1'b0, "R11 out_valid", 32'(out_valid), 0);
        chk(mf_start == 1'b0 && mf_end == 1'b0, "R11 flags",
            {30'd0, mf_start, mf_end}, 0);
        chk(lane_data == '0, "R11 lane_data", lane_data[31:0], 0);
    endtask

    task automatic step(input bit v, input bit ls, input bit tr);
        logic [13:0] smp [NS];
        bit acc;
        bit exp_sof, exp_eof;
        for (int i = 0; i < NS; i++) begin
            smp[i] = gen(beat_id, i);
            in_samples[i*RB +: RB] = smp[i];
        end
        in_valid   = v;
        link_start = ls;
        tail_rand  = tr;
        #1;
        chk(in_ready == ls, "R7 in_ready", 32'(in_ready), 32'(ls));
        acc = v && ls;
        exp_sof = acc && (beat_no == 0);
        exp_eof = acc && (beat_no == 7);
        if (acc) begin
            for (int i = 0; i < NS; i++) begin
                int f = i / 4;
                int k = i % 4;
                logic [15:0] d;
                d = {smp[i], tail_of(n_acc + i, tr)};
                exp_lanes[(2*k)*32 + f*8 +: 8]   = d[15:8];
                exp_lanes[(2*k+1)*32 + f*8 +: 8] = d[7:0];
            end
            n_acc += NS;
        end
        if (!ls) beat_no = 0;
        else if (acc) beat_no = (beat_no + 1) % 8;
        @(posedge clk);
        #1;
        chk(out_valid == acc, "R6 out_valid", 32'(out_valid), 32'(acc));
        chk(mf_start == exp_sof, "R8 R9 mf_start", 32'(mf_start), 32'(exp_sof));
        chk(mf_end == exp_eof, "R8 mf_end", 32'(mf_end), 32'(exp_eof));
        chk(frame_end == '1, "R10 frame_end", frame_end, 32'hFFFF_FFFF);
        for (int l = 0; l < NL; l++) begin
            for (int f = 0; f < 4; f++) begin
                logic [7:0] a, e;
                a = lane_data[l*32 + f*8 +: 8];
                e = exp_lanes[l*32 + f*8 +: 8];
                if (l % 2 == 0) begin
                    chk(a == e, acc ? "R1 R3 high octet" : "R6 hold high octet",
                        32'(a), 32'(e));
                end else begin
                    chk(a[7:2] == e[7:2], acc ? "R2 R3 low octet" : "R6 hold low octet",
                        32'(a), 32'(e));
                    chk(a[1:0] == e[1:0], tr ? "R5 tail sequence" : "R4 zero tail",
                        32'(a[1:0]), 32'(e[1:0]));
                end
            end
        end
        beat_id++;
    endtask

    initial begin
        link_start = 1'b0;
        tail_rand  = 1'b0;
        in_valid   = 1'b0;
        in_samples = '0;
        do_reset();
        // zero tails, back-to-back, several multiframes
        for (int b = 0; b < 20; b++) step(1'b1, 1'b1, 1'b0);
        // stalls: data must hold
        for (int b = 0; b < 10; b++) step(b % 2 == 0, 1'b1, 1'b0);
        // link drop mid multiframe, offered data refused (R9)
        for (int b = 0; b < 3; b++) step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        for (int b = 0; b < 10; b++) step(1'b1, 1'b1, 1'b0);
        // random tails with gaps
        for (int b = 0; b < 30; b++) step(b % 4 != 2, 1'b1, 1'b1);
        // mode toggling every beat
        for (int b = 0; b < 12; b++) step(1'b1, 1'b1, b % 2 == 1);
        // reset restarts sequence and count
        do_reset();
        for (int b = 0; b < 10; b++) step(1'b1, 1'b1, 1'b1);
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule